// File: doc/BRIEF.md
# Interrupt Coalescing and Credit Controller

This block moderates a single interrupt vector. A one-cycle event input asks for an interrupt; the block turns it into a one-cycle send pulse when the vector is unmasked and its hold-off timer has run out. An event that cannot be sent at once is remembered in a pending flag and sent as soon as the blocking condition clears. Every send reloads the hold-off timer from a programmable initial value. The timer then counts down on pulses from an external tick input, and an optional auto-mask control sets the mask on every send.

The block also keeps a signed count of sent interrupts. Software acknowledges handled events by writing a decrement to the credit word. The same write can also unmask the vector and restart the hold-off timer. When an acknowledge brings the count to zero, any event still waiting is dropped. Software reaches all of this through a word-wide register port with a 32-byte window. Accesses are 32-bit words, and the two low address bits are ignored.

Top module: `intr_moderator`

## Requirements
- R1: After reset the mask reads 1 (offset 0x04), and the initial timer value (0x00), the credit count (0x08), auto-mask (0x0C), current timer (0x10), the pending output and the send output are all 0.
- R2: An event in a cycle where the mask is 0 and the current timer is 0 produces a send pulse one cycle later. With an initial timer value of 0, every unmasked event sends.
- R3: While the mask is 1 nothing is sent and an event sets pending. Clearing the mask, either by writing 0 to bit 0 at 0x04 or by a credit write with bit 16 set, sends a pending event one cycle after the write.
- R4: A send loads the current timer from the initial value. The timer decrements by one on each tick pulse and holds at 0. While it is nonzero no send occurs and events go pending. A pending event is sent in the cycle after the timer reaches 0.
- R5: With auto-mask (bit 0 at 0x0C) set to 1, each send sets the mask to 1. With it set to 0, a send leaves the mask unchanged.
- R6: The credit count is a 16-bit two's-complement value. It rises by one per send. A write to 0x08 subtracts bits 15:0 of the write data, modulo 2^16, and the count reads back zero-extended in bits 15:0.
- R7: A credit write that leaves the count at 0 clears pending, so a later unmask sends nothing.
- R8: An event in the same cycle as a credit write that brings the count to 0 still leaves pending set.
- R9: A credit write with bit 17 set reloads the current timer from the initial value.
- R10: The initial value keeps only bits 5:0 of a write. Offset 0x10 is read-only. Offsets 0x14 to 0x1C read 0 and ignore writes. Bits 31:16 of the credit word read 0.
- R11: The pending output mirrors the internal pending flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer decrement pulse from an external prescaler |
| evt | input | 1 | One-cycle interrupt event |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte offset within the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqSend | output | 1 | One-cycle interrupt send pulse |
| irqPending | output | 1 | Pending status |

## Verification
The bench builds the block with its default widths: a 6-bit timer and a 16-bit credit count. The 6-bit timer lets a hold-off of three ticks, the tick hold at zero and the 0x3F truncation all be reached in a few dozen cycles. With the 16-bit count, the signed wrap past zero (0xFFFE), and a subtraction of a negative amount that restores zero, are reached with single writes. The bench also builds the same-cycle collision of an event with a zeroing credit write, and the recovery from it.

// File: rtl/intr_mod_pkg.sv
package intr_mod_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  // Word indices inside the 32-byte window.
  localparam logic [IDX_W-1:0] IDX_INIT = 3'd0;
  localparam logic [IDX_W-1:0] IDX_MASK = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CRED = 3'd2;
  localparam logic [IDX_W-1:0] IDX_AUTO = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CURR = 3'd4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic sendNow;
    logic reloadReq;
    logic credWr;
    logic initWr;
  } strobeT;

endpackage

// File: rtl/intr_mod_dpath.sv
module intr_mod_dpath
  import intr_mod_pkg::*;
#(
  parameter int TIMER_W = 6,
  parameter int CRED_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  strobeT            strb,
  input  logic [CRED_W-1:0] credData,
  output logic [TIMER_W-1:0] initQ,
  output logic [TIMER_W-1:0] timerQ,
  output logic [CRED_W-1:0] credQ,
  output logic              timerZero,
  output logic              credHitsZero
);

  logic [CRED_W-1:0] credNext;
  logic [CRED_W-1:0] credInc;
  logic [CRED_W-1:0] credDec;

  always_comb begin
    credInc      = {{(CRED_W-1){1'b0}}, strb.sendNow};
    credDec      = strb.credWr ? credData : '0;
    credNext     = credQ + credInc - credDec;
    credHitsZero = strb.credWr && (credNext == '0);
    timerZero    = (timerQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ  <= '0;
      timerQ <= '0;
      credQ  <= '0;
    end else begin
      if (strb.initWr) initQ <= credData[TIMER_W-1:0];
      if (strb.sendNow || strb.reloadReq) timerQ <= initQ;
      else if (tick && !timerZero) timerQ <= timerQ - 1'b1;
      credQ <= credNext;
    end
  end

  // R4: a send loads the hold-off timer
  a_r4_load_on_send: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendNow |=> timerQ == $past(initQ));

  // R4: the timer holds at zero
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    (timerQ == '0 && !strb.sendNow && !strb.reloadReq) |=> timerQ == '0);

  // R4: one step per tick
  a_r4_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    (timerQ != '0 && tick && !strb.sendNow && !strb.reloadReq)
      |=> timerQ == $past(timerQ) - 1'b1);

  // R6: each send without a write adds one credit
  a_r6_send_counts: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sendNow && !strb.credWr) |=> credQ == $past(credQ) + 1'b1);

  // R9: a reload request restarts the timer
  a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
    strb.reloadReq |=> timerQ == $past(initQ));

endmodule

// File: rtl/intr_mod_ctrl.sv
module intr_mod_ctrl
  import intr_mod_pkg::*;
#(
  parameter int CRED_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  input  logic             busWr,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             dataBit0,
  input  logic             unmaskBit,
  input  logic             reloadBit,
  input  logic             timerZero,
  input  logic             credHitsZero,
  output strobeT           strb,
  output logic             maskQ,
  output logic             autoQ,
  output logic             pendQ,
  output logic             irqSendQ
);

  logic maskWr;
  logic autoWr;
  logic unmaskReq;

  always_comb begin
    strb.initWr    = busWr && (wrIdx == IDX_INIT);
    strb.credWr    = busWr && (wrIdx == IDX_CRED);
    strb.reloadReq = strb.credWr && reloadBit;
    strb.sendNow   = !maskQ && timerZero && (evt || pendQ);
    maskWr         = busWr && (wrIdx == IDX_MASK);
    autoWr         = busWr && (wrIdx == IDX_AUTO);
    unmaskReq      = strb.credWr && unmaskBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= 1'b1;
      autoQ    <= 1'b0;
      pendQ    <= 1'b0;
      irqSendQ <= 1'b0;
    end else begin
      irqSendQ <= strb.sendNow;
      if (strb.sendNow && autoQ) maskQ <= 1'b1;
      else if (unmaskReq)        maskQ <= 1'b0;
      else if (maskWr)           maskQ <= dataBit0;
      if (autoWr) autoQ <= dataBit0;
      if (strb.sendNow)     pendQ <= 1'b0;
      else if (evt)         pendQ <= 1'b1;
      else if (credHitsZero) pendQ <= 1'b0;
    end
  end

  // R3: no send pulse follows a masked cycle
  a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rstN)
    irqSendQ |-> $past(!maskQ));

  // R5: auto-mask sets the mask on every send
  a_r5_auto_mask: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sendNow && autoQ) |=> maskQ);

  // R7: zeroing acknowledge drops pending
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (credHitsZero && !evt && !strb.sendNow) |=> !pendQ);

  // R8: an unsent event is always recorded
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !strb.sendNow) |=> pendQ);

endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
  import intr_mod_pkg::*;
#(
  parameter int TIMER_W = 6,
  parameter int CRED_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              evt,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqSend,
  output logic              irqPending
);

  localparam int UNMASK_BIT = CRED_W;
  localparam int RELOAD_BIT = CRED_W + 1;

  strobeT              strb;
  logic                timerZero;
  logic                credHitsZero;
  logic                maskQ;
  logic                autoQ;
  logic                pendQ;
  logic [TIMER_W-1:0]  initQ;
  logic [TIMER_W-1:0]  timerQ;
  logic [CRED_W-1:0]   credQ;
  logic [IDX_W-1:0]    wordIdx;
  logic                unusedWdata;

  assign wordIdx     = busAddr[ADDR_W-1:2];
  assign unusedWdata = ^{busWdata[DATA_W-1:RELOAD_BIT+1], busAddr[1:0]};

  intr_mod_ctrl #(.CRED_W(CRED_W)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .busWr        (busWr),
    .wrIdx        (wordIdx),
    .dataBit0     (busWdata[0]),
    .unmaskBit    (busWdata[UNMASK_BIT]),
    .reloadBit    (busWdata[RELOAD_BIT]),
    .timerZero    (timerZero),
    .credHitsZero (credHitsZero),
    .strb         (strb),
    .maskQ        (maskQ),
    .autoQ        (autoQ),
    .pendQ        (pendQ),
    .irqSendQ     (irqSend)
  );

  intr_mod_dpath #(.TIMER_W(TIMER_W), .CRED_W(CRED_W)) dpath (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .strb         (strb),
    .credData     (busWdata[CRED_W-1:0]),
    .initQ        (initQ),
    .timerQ       (timerQ),
    .credQ        (credQ),
    .timerZero    (timerZero),
    .credHitsZero (credHitsZero)
  );

  assign irqPending = pendQ;

  always_comb begin
    case (wordIdx)
      IDX_INIT: busRdata = DATA_W'(initQ);
      IDX_MASK: busRdata = DATA_W'(maskQ);
      IDX_CRED: busRdata = DATA_W'(credQ);
      IDX_AUTO: busRdata = DATA_W'(autoQ);
      IDX_CURR: busRdata = DATA_W'(timerQ);
      default:  busRdata = '0;
    endcase
  end

  // R2: a send pulse lasts one cycle unless a second send follows
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (irqSend && autoQ) |=> !irqSend);

endmodule

// File: tb/intr_moderator_test.sv
module intr_moderator_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        evt = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqSend;
  logic        irqPending;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  intr_moderator uut (
    .clk(clk), .rstN(rstN), .tick(tick), .evt(evt), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqSend(irqSend), .irqPending(irqPending)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic regRead(input logic [4:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdata, exp, tag);
  endtask

  // Event captured at one edge; send output visible at the following negedge.
  task automatic pulseEvt();
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic testReset();
    regRead(5'h00, 32'h0, "R1 init");
    regRead(5'h04, 32'h1, "R1 mask");
    regRead(5'h08, 32'h0, "R1 credits");
    regRead(5'h0C, 32'h0, "R1 auto");
    regRead(5'h10, 32'h0, "R1 timer");
    check(irqPending, 1'b0, "R1 pending");
    check(irqSend, 1'b0, "R1 send");
  endtask

  task automatic testMaskedPending();
    pulseEvt();
    check(irqSend, 1'b0, "R3 masked no send");
    check(irqPending, 1'b1, "R3 R11 pending set");
    regWrite(5'h04, 32'h0);
    @(negedge clk);
    check(irqSend, 1'b1, "R3 unmask sends pending");
    check(irqPending, 1'b0, "R11 pending cleared");
    regRead(5'h08, 32'h1, "R6 one credit");
  endtask

  task automatic testNoCoalesce();
    for (int i = 0; i < 3; i++) begin
      pulseEvt();
      check(irqSend, 1'b1, "R2 every event sends");
    end
    regRead(5'h08, 32'h4, "R6 credits after four");
  endtask

  task automatic testHoldOff();
    regWrite(5'h00, 32'h3);
    pulseEvt();
    check(irqSend, 1'b1, "R2 send with timer idle");
    regRead(5'h10, 32'h3, "R4 timer loaded");
    pulseEvt();
    check(irqSend, 1'b0, "R4 blocked by timer");
    check(irqPending, 1'b1, "R4 pending while held");
    tickOnce(); tickOnce();
    regRead(5'h10, 32'h1, "R4 timer counts ticks");
    check(irqSend, 1'b0, "R4 still held");
    tickOnce();
    @(negedge clk);
    check(irqSend, 1'b1, "R4 pending sent at zero");
    regRead(5'h10, 32'h3, "R4 reload on send");
    for (int i = 0; i < 8; i++) tickOnce();
    regRead(5'h10, 32'h0, "R4 holds at zero");
    regRead(5'h08, 32'h6, "R6 credits six");
  endtask

  task automatic testReloadAndSign();
    regWrite(5'h08, 32'h0002_0000);
    regRead(5'h10, 32'h3, "R9 reload flag");
    regRead(5'h08, 32'h6, "R9 zero decrement");
    regWrite(5'h08, 32'h8);
    regRead(5'h08, 32'hFFFE, "R6 signed below zero");
    regWrite(5'h08, 32'hFFFE);
    regRead(5'h08, 32'h0, "R6 subtract negative");
  endtask

  task automatic testAutoMask();
    regWrite(5'h00, 32'h0);
    for (int i = 0; i < 3; i++) tickOnce();
    regWrite(5'h0C, 32'h1);
    pulseEvt();
    check(irqSend, 1'b1, "R5 send");
    regRead(5'h04, 32'h1, "R5 auto mask set");
    pulseEvt();
    check(irqSend, 1'b0, "R5 masked after send");
    regWrite(5'h08, 32'h0001_0000);
    @(negedge clk);
    check(irqSend, 1'b1, "R3 unmask flag sends");
    regRead(5'h04, 32'h1, "R5 masked again");
    regRead(5'h08, 32'h2, "R6 credits two");
  endtask

  task automatic testZeroClear();
    pulseEvt();
    check(irqPending, 1'b1, "R7 pending before ack");
    regWrite(5'h08, 32'h2);
    check(irqPending, 1'b0, "R7 zero clears pending");
    regWrite(5'h04, 32'h0);
    @(negedge clk);
    check(irqSend, 1'b0, "R7 nothing sent");
  endtask

  task automatic testCollision();
    regWrite(5'h04, 32'h1);
    regWrite(5'h08, 32'hFFFF);
    regRead(5'h08, 32'h1, "R8 credits one");
    @(negedge clk);
    evt = 1'b1; busWr = 1'b1; busAddr = 5'h08; busWdata = 32'h1;
    @(negedge clk);
    evt = 1'b0; busWr = 1'b0; busWdata = '0;
    check(irqPending, 1'b1, "R8 event beats clear");
    regRead(5'h08, 32'h0, "R8 credits zero");
    regWrite(5'h04, 32'h0);
    @(negedge clk);
    check(irqSend, 1'b1, "R8 kept event sent");
  endtask

  task automatic testMap();
    regWrite(5'h00, 32'hFFFF_FFFF);
    regRead(5'h00, 32'h3F, "R10 init width");
    regWrite(5'h10, 32'h15);
    regRead(5'h10, 32'h0, "R10 timer read-only");
    regWrite(5'h14, 32'hFFFF_FFFF);
    regRead(5'h14, 32'h0, "R10 reserved 0x14");
    regRead(5'h18, 32'h0, "R10 reserved 0x18");
    regRead(5'h1C, 32'h0, "R10 reserved 0x1C");
    regRead(5'h08, 32'h1, "R10 credit upper zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskedPending();
    testNoCoalesce();
    testHoldOff();
    testReloadAndSign();
    testAutoMask();
    testZeroClear();
    testCollision();
    testMap();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule